// File: doc/BRIEF.md
# Ternary Header Classifier

This block decides what to do with a packet by comparing a header key against a table of ternary rules. Each rule has three parts: a value, a per-bit care mask and a live flag. Every rule is compared with the key at the same time. A bit whose care bit is 0 is ignored in the comparison. When more than one rule matches, the one with the lowest table position wins. Its position selects a word in a separate action table, and that word is returned as the verdict.

The key is packed from three header fields: destination, source and protocol. A field that a rule does not care about has all of its care bits cleared. Port ranges are turned into prefix rules before they are loaded, so one policy may occupy several table positions. Two write ports load rules and actions. A search is started by strobing the search enable with a key. The registered verdict appears one clock later.

Top module: `tcls_classifier`

## Requirements
- R1: A live rule matches when, for every key bit whose care bit is 1, the key bit equals the rule's value bit. Key bits whose care bit is 0 do not affect the match. The key is packed as destination in bits 19:12, source in bits 11:4 and protocol in bits 3:0.
- R2: A live rule whose care mask is all zero matches every key, whatever its stored value.
- R3: A rule whose live flag is 0 never matches. Reset clears the live flag of every position.
- R4: When several rules match, the verdict reports the lowest matching position.
- R5: On a hit, the reported action is the action-table word at the winning position.
- R6: When no live rule matches, the hit flag is 0 and both the reported index and the reported action are 0.
- R7: The result-valid output is 1 exactly in the cycle after a search strobe. In cycles without a search, the hit flag, index and action keep their previous values. Reset clears all outputs.
- R8: A search in the same cycle as a rule write or an action write uses the table contents from before that write. The new contents are used by the next search.
- R9: Writing a position replaces its earlier value, care mask and live flag in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rule_we | input | 1 | Rule write strobe |
| rule_idx | input | IDX_W | Rule position to write |
| rule_value | input | KEY_W | Value bits of the rule |
| rule_care | input | KEY_W | Care mask; 1 means the bit is compared |
| rule_live | input | 1 | Live flag stored with the rule |
| act_we | input | 1 | Action write strobe |
| act_idx | input | IDX_W | Action position to write |
| act_data | input | ACT_W | Action word |
| srch_en | input | 1 | Search strobe |
| srch_key | input | KEY_W | Header key to classify |
| res_valid | output | 1 | Result of last cycle's search is present |
| res_hit | output | 1 | Some live rule matched |
| res_idx | output | IDX_W | Winning rule position |
| res_action | output | ACT_W | Action word of the winning rule |

## Verification
The hardest case to reach is a search in the same cycle as a write that would change its outcome. The bench issues the search and the write in one cycle. First it searches with a key that only the rule being written would match, so the expected result is a miss. Then it searches with a key that hits the position whose action word is being rewritten, so the expected action is the old word. The search in the following cycle must see the new contents. Priority is tested by keeping three overlapping rules live: an exact rule, a destination-only rule and a full wildcard. A key that all three match has to resolve to the lowest of them.

// File: rtl/tcls_pkg.sv
package tcls_pkg;

    localparam int DST_W   = 8;
    localparam int SRC_W   = 8;
    localparam int PROTO_W = 4;

    typedef struct packed {
        logic [DST_W-1:0]   dst;
        logic [SRC_W-1:0]   src;
        logic [PROTO_W-1:0] proto;
    } hdr_key_t;

    localparam int KEY_W = $bits(hdr_key_t);

    typedef struct packed {
        logic [KEY_W-1:0] value;
        logic [KEY_W-1:0] care;
        logic             live;
    } tern_rule_t;

    function automatic logic tern_hit(input tern_rule_t r, input logic [KEY_W-1:0] k);
        return r.live && (((k ^ r.value) & r.care) == '0);
    endfunction

endpackage

// File: rtl/tcls_rule_array.sv
module tcls_rule_array
    import tcls_pkg::*;
#(
    parameter int NUM_RULES = 16,
    parameter int IDX_W     = $clog2(NUM_RULES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  tern_rule_t           wr_rule,
    input  logic [KEY_W-1:0]     key,
    output logic [NUM_RULES-1:0] match
);

    generate
        for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
            tern_rule_t slot;

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    slot <= wr_rule;
                end
            end

            assign match[g] = tern_hit(slot, key);
        end
    endgenerate

endmodule

// File: rtl/tcls_prio_enc.sv
module tcls_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        grant = found ? (ONE << idx) : '0;
    end

endmodule

// File: rtl/tcls_action_mem.sv
module tcls_action_mem #(
    parameter int DEPTH = 16,
    parameter int ACT_W = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ACT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ACT_W-1:0] rd_data
);

    logic [ACT_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/tcls_classifier.sv
module tcls_classifier
    import tcls_pkg::*;
#(
    parameter int NUM_RULES = 16,
    parameter int ACT_W     = 8,
    localparam int IDX_W    = $clog2(NUM_RULES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rule_we,
    input  logic [IDX_W-1:0] rule_idx,
    input  logic [KEY_W-1:0] rule_value,
    input  logic [KEY_W-1:0] rule_care,
    input  logic             rule_live,
    input  logic             act_we,
    input  logic [IDX_W-1:0] act_idx,
    input  logic [ACT_W-1:0] act_data,
    input  logic             srch_en,
    input  logic [KEY_W-1:0] srch_key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx,
    output logic [ACT_W-1:0] res_action
);

    localparam logic [NUM_RULES-1:0] ONE = {{(NUM_RULES-1){1'b0}}, 1'b1};

    tern_rule_t           wr_rule;
    logic [NUM_RULES-1:0] match;
    logic [NUM_RULES-1:0] grant;
    logic                 found;
    logic [IDX_W-1:0]     win_idx;
    logic [ACT_W-1:0]     win_act;

    assign wr_rule = '{value: rule_value, care: rule_care, live: rule_live};

    tcls_rule_array #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_rules (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rule_we),
        .wr_idx  (rule_idx),
        .wr_rule (wr_rule),
        .key     (srch_key),
        .match   (match)
    );

    tcls_prio_enc #(.N(NUM_RULES), .IDX_W(IDX_W)) u_enc (
        .req   (match),
        .found (found),
        .idx   (win_idx),
        .grant (grant)
    );

    tcls_action_mem #(.DEPTH(NUM_RULES), .ACT_W(ACT_W), .IDX_W(IDX_W)) u_act (
        .clk     (clk),
        .wr_en   (act_we),
        .wr_idx  (act_idx),
        .wr_data (act_data),
        .rd_idx  (win_idx),
        .rd_data (win_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_idx    <= '0;
            res_action <= '0;
        end else begin
            res_valid <= srch_en;
            if (srch_en) begin
                res_hit    <= found;
                res_idx    <= found ? win_idx : '0;
                res_action <= found ? win_act : '0;
            end
        end
    end

    // R4: the encoder's winner matches and no lower position matches
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        found |-> (match[win_idx] && ((match & ((ONE << win_idx) - ONE)) == '0)));

    // R4: the grant is one-hot and empty exactly when nothing matches
    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant == '0) == (match == '0)));

    // R7: result-valid follows a search strobe by one cycle
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        srch_en |=> res_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !srch_en |=> (!res_valid && $stable(res_hit) && $stable(res_idx) && $stable(res_action)));

    // R6: a miss reports zero index and zero action
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_idx == '0 && res_action == '0));

endmodule

// File: tb/test_tcls_classifier.sv
module test_tcls_classifier;

    localparam int N  = 16;
    localparam int IW = 4;
    localparam int KW = 20;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rule_we = 1'b0;
    logic [IW-1:0] rule_idx = '0;
    logic [KW-1:0] rule_value = '0;
    logic [KW-1:0] rule_care = '0;
    logic          rule_live = 1'b0;
    logic          act_we = 1'b0;
    logic [IW-1:0] act_idx = '0;
    logic [AW-1:0] act_data = '0;
    logic          srch_en = 1'b0;
    logic [KW-1:0] srch_key = '0;
    logic          res_valid, res_hit;
    logic [IW-1:0] res_idx;
    logic [AW-1:0] res_action;

    always #2 clk = ~clk;

    tcls_classifier #(.NUM_RULES(N), .ACT_W(AW)) i_tcls_classifier (
        .clk(clk), .rst(rst),
        .rule_we(rule_we), .rule_idx(rule_idx), .rule_value(rule_value),
        .rule_care(rule_care), .rule_live(rule_live),
        .act_we(act_we), .act_idx(act_idx), .act_data(act_data),
        .srch_en(srch_en), .srch_key(srch_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_action(res_action)
    );

    typedef struct {
        logic          hit;
        logic [IW-1:0] idx;
        logic [AW-1:0] act;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [KW-1:0] m_val [N];
    logic [KW-1:0] m_care[N];
    logic          m_live[N];
    logic [AW-1:0] m_act [N];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done  = 0;

    function automatic logic [KW-1:0] mk(input logic [7:0] d, input logic [7:0] s, input logic [3:0] p);
        return {d, s, p};
    endfunction

    function automatic exp_t predict(input logic [KW-1:0] key, input string tag);
        exp_t e;
        e.hit = 1'b0; e.idx = '0; e.act = '0; e.tag = tag;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_live[i] && (((key ^ m_val[i]) & m_care[i]) == '0)) begin
                e.hit = 1'b1; e.idx = IW'(i); e.act = m_act[i];
            end
        end
        return e;
    endfunction

    task automatic drive(input logic rwe, input logic [IW-1:0] ridx, input logic [KW-1:0] rv,
                         input logic [KW-1:0] rc, input logic rl, input logic awe,
                         input logic [IW-1:0] aidx, input logic [AW-1:0] ad,
                         input logic se, input logic [KW-1:0] key, input string tag);
        @(posedge clk); #1;
        rule_we = rwe; rule_idx = ridx; rule_value = rv; rule_care = rc; rule_live = rl;
        act_we = awe; act_idx = aidx; act_data = ad;
        srch_en = se; srch_key = key;
        if (se) sb.push_back(predict(key, tag));
        if (rwe) begin m_val[ridx] = rv; m_care[ridx] = rc; m_live[ridx] = rl; end
        if (awe) m_act[aidx] = ad;
    endtask

    task automatic idle();
        drive(0, '0, '0, '0, 0, 0, '0, '0, 0, '0, "");
    endtask

    task automatic put_rule(input int i, input logic [KW-1:0] v, input logic [KW-1:0] c, input logic l);
        drive(1, IW'(i), v, c, l, 0, '0, '0, 0, '0, "");
    endtask

    task automatic put_act(input int i, input logic [AW-1:0] a);
        drive(0, '0, '0, '0, 0, 1, IW'(i), a, 0, '0, "");
    endtask

    task automatic look(input logic [KW-1:0] key, input string tag);
        drive(0, '0, '0, '0, 0, 0, '0, '0, 1, key, tag);
    endtask

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitor: compare each result against the scoreboard
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                check(0, $sformatf("R7 unexpected result hit=%0b idx=%0d, expected none", res_hit, res_idx));
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(res_hit == e.hit && res_idx == e.idx && res_action == e.act,
                      $sformatf("%s actual hit=%0b idx=%0d act=%h expected hit=%0b idx=%0d act=%h",
                                e.tag, res_hit, res_idx, res_action, e.hit, e.idx, e.act));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        logic          h_hit;
        logic [IW-1:0] h_idx;
        logic [AW-1:0] h_act;

        for (int i = 0; i < N; i++) begin
            m_val[i] = '0; m_care[i] = '0; m_live[i] = 1'b0; m_act[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(res_valid == 0 && res_hit == 0 && res_idx == 0 && res_action == 0,
              $sformatf("R7 reset outputs actual v=%0b h=%0b i=%0d a=%h expected all 0",
                        res_valid, res_hit, res_idx, res_action));

        // R3: table empty after reset, even a plain key misses
        look(mk(8'h00, 8'h00, 4'h0), "R3 empty table");

        for (int i = 0; i < N; i++) put_act(i, AW'(8'hA0 + i));

        put_rule(5, mk(8'h0A, 8'h14, 4'h6), 20'hFFFFF, 1);         // exact
        put_rule(9, mk(8'h0A, 8'h00, 4'h0), mk(8'hFF, 8'h00, 4'h0), 1); // dst only
        put_rule(15, 20'hABCDE, 20'h00000, 1);                     // full wildcard
        put_rule(2, 20'h00000, 20'h00000, 0);                      // wildcard but not live

        look(mk(8'h0A, 8'h14, 4'h6), "R4 three rules match, lowest wins");
        look(mk(8'h0A, 8'h33, 4'h6), "R1 dst-only rule ignores source");
        look(mk(8'h0A, 8'h14, 4'h7), "R1 protocol bit differs on exact rule");
        look(mk(8'h0B, 8'h14, 4'h6), "R2 wildcard catches the rest");
        look(mk(8'hFF, 8'hFF, 4'hF), "R5 wildcard action word");

        put_rule(15, 20'hABCDE, 20'h00000, 0);
        look(mk(8'h0B, 8'h00, 4'h0), "R6 miss after wildcard retired");

        // R8: rule write and search in one cycle, then next cycle
        drive(1, 4'd3, 20'h00000, 20'h00000, 1, 0, '0, '0, 1, mk(8'h0B, 8'h01, 4'h1),
              "R8 same-cycle rule write sees old table");
        look(mk(8'h0B, 8'h01, 4'h1), "R8 next search sees new rule");

        // R8: action write and search in one cycle
        drive(0, '0, '0, '0, 0, 1, 4'd3, 8'h5C, 1, mk(8'h0A, 8'h14, 4'h6),
              "R8 same-cycle action write sees old word");
        look(mk(8'h0A, 8'h14, 4'h6), "R5 new action word at winner");

        // R9: overwrite rule 3 with a dst-only rule
        put_rule(3, mk(8'h77, 8'h00, 4'h0), mk(8'hFF, 8'h00, 4'h0), 1);
        look(mk(8'h0B, 8'h01, 4'h1), "R9 old wildcard gone");
        look(mk(8'h77, 8'h42, 4'h9), "R9 new rule content");
        look(mk(8'h0A, 8'h14, 4'h6), "R4 exact rule wins over higher dst rule");

        // R7: back-to-back searches
        look(mk(8'h77, 8'h00, 4'h0), "R7 back-to-back 1");
        look(mk(8'h0A, 8'hEE, 4'h2), "R7 back-to-back 2");
        look(mk(8'h10, 8'h10, 4'h1), "R7 back-to-back 3");
        look(mk(8'h0A, 8'h14, 4'h6), "R7 back-to-back 4");

        // R7: outputs hold across idle cycles
        idle();
        @(negedge clk);
        h_hit = res_hit; h_idx = res_idx; h_act = res_action;
        repeat (3) idle();
        @(negedge clk);
        check(res_valid == 0 && res_hit == h_hit && res_idx == h_idx && res_action == h_act,
              $sformatf("R7 hold actual v=%0b h=%0b i=%0d a=%h expected v=0 h=%0b i=%0d a=%h",
                        res_valid, res_hit, res_idx, res_action, h_hit, h_idx, h_act));

        // R3: retire every rule, all keys miss
        put_rule(3, '0, '0, 0);
        put_rule(5, '0, '0, 0);
        put_rule(9, '0, '0, 0);
        look(mk(8'h0A, 8'h14, 4'h6), "R3 all rules retired");

        repeat (4) idle();
        check(sb.size() == 0, $sformatf("R7 pending results actual %0d expected 0", sb.size()));
        finish_run();
    end

endmodule